// File: doc/BRIEF.md
# Reversible Gate Cascade Engine

This block evaluates a cascade of reversible gates over a vector of 13 one-bit lines, applying one gate per clock cycle. The gates sit in a small program store. Each entry gives a gate kind and the lines it acts on. Entries are executed in order from address 0 upward, or from the last address downward to undo a computation. Because every supported gate can be inverted, a forward run followed by a reverse run returns the exact starting vector, constant lines included. While the engine runs, it adds up the quantum cost of every gate it applies.

Out of reset, the store holds a 20-entry Toffoli program that acts as a 4-bit AND/OR unit. Lines 12..9 are constant inputs that must be driven to 1, and they carry the result. Lines 8..5 hold operand A (bit k on line 5+k) and lines 4..1 hold operand B (bit k on line 1+k). Line 0 is the operation select. The remaining store entries are empty. A caller can overwrite any entry through the load port while the engine is idle. To start a run, the caller pulses `start`, with `reverse` giving the direction. The caller then waits for `done`.

Top module: `rgc_engine`

## Requirements
- R1: After reset, line_out, busy, done, cost and err are all 0, and the store holds the default program.
- R2: Entry format, 28 bits: [27:25] kind (0 empty, 1 invert, 2 controlled-NOT, 3 multi-control Toffoli, 4 Peres, 5 Fredkin, 6 and 7 illegal), [24:12] control mask, [11:8] line ta, [7:4] line tb, [3:0] line tc. An empty entry changes nothing and costs 0.
- R3: A Toffoli entry flips line ta when every line set in the mask is 1. An empty mask flips ta unconditionally, and any number of controls from 0 to 12 is allowed.
- R4: Invert flips ta. Controlled-NOT XORs line tb into ta. Peres, with A=tc, B=tb and C=ta, gives C^=A&B and B^=A. Fredkin swaps ta and tb when tc is 1.
- R5: Reverse runs execute addresses from last to first and apply each gate's inverse. For Peres, the inverse is B^=A followed by C^=A&B. A forward run followed by a reverse run restores the input vector.
- R6: cost is cleared at start and grows by the cost of each applied gate: invert 0, controlled-NOT 1, Peres 4, Toffoli 5, Fredkin 5.
- R7: A run lasts exactly DEPTH gate cycles. done is a single-cycle pulse that appears together with the final vector, DEPTH+1 cycles after the start edge. line_out holds its value while the engine is idle.
- R8: start, and program store writes, have no effect while busy is high.
- R9: An entry is illegal if its kind is 6 or 7, if it uses an index above 12, if a Toffoli mask contains ta, if a controlled-NOT has ta equal to tb, or if a Peres or Fredkin entry repeats an index. Such an entry is skipped with no line change and no cost, and it sets err. err stays set until reset.
- R10: With the default program and lines 12..9 at 1, result bit k on line 9+k is A&B when select is 0 and A|B when select is 1. Lines for B and select are unchanged. Line 5+k becomes A_k when select is 0 and ~A_k&B_k when select is 1. The cost of such a run is 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; sampled only while idle |
| reverse | input | 1 | 1 runs the cascade backward |
| line_in | input | 13 | Initial line vector, captured at start |
| prog_we | input | 1 | Program store write strobe, ignored while busy |
| prog_addr | input | ADDR_W | Program store write address |
| prog_data | input | 28 | Gate entry to write |
| line_out | output | 13 | Current line vector |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse when the run completes |
| cost | output | COST_W | Accumulated quantum cost of the current or last run |
| err | output | 1 | Sticky flag for a skipped illegal entry |

## Verification
A wrong gate evaluation or a wrong step order leaves its mark on line_out when done rises. The round-trip check then shows it a second time: after the reverse run, line_out differs from the captured input. A wrong sequencer count moves the done pulse off cycle DEPTH+1, which is visible in the same run. A cost or skip error shows up in cost and err at that same done pulse. The exhaustive sweep of all 512 operand and select combinations exposes any corrupted default entry within one run.

// File: rtl/rgc_pkg.sv
package rgc_pkg;

  localparam int NLINES  = 13;
  localparam int IDX_W   = 4;
  localparam int GATE_W  = 28;
  localparam int ALU_LEN = 20;

  typedef enum logic [2:0] {
    K_NOP  = 3'd0,
    K_INV  = 3'd1,
    K_CNOT = 3'd2,
    K_TOF  = 3'd3,
    K_PER  = 3'd4,
    K_FRED = 3'd5,
    K_BAD6 = 3'd6,
    K_BAD7 = 3'd7
  } kind_e;

  typedef struct packed {
    kind_e               kind;
    logic [NLINES-1:0]   mask;
    logic [IDX_W-1:0]    ta;
    logic [IDX_W-1:0]    tb;
    logic [IDX_W-1:0]    tc;
  } gate_t;

  function automatic logic [2:0] gate_cost(kind_e k);
    case (k)
      K_CNOT:  return 3'd1;
      K_TOF:   return 3'd5;
      K_PER:   return 3'd4;
      K_FRED:  return 3'd5;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic idx_bad(logic [IDX_W-1:0] i);
    return i > IDX_W'(NLINES - 1);
  endfunction

  function automatic logic gate_bad(gate_t g);
    logic trio_dup;
    trio_dup = (g.ta == g.tb) || (g.ta == g.tc) || (g.tb == g.tc);
    case (g.kind)
      K_NOP:   return 1'b0;
      K_INV:   return idx_bad(g.ta);
      K_CNOT:  return idx_bad(g.ta) || idx_bad(g.tb) || (g.ta == g.tb);
      K_TOF:   return idx_bad(g.ta) ? 1'b1 : g.mask[g.ta];
      K_PER,
      K_FRED:  return idx_bad(g.ta) || idx_bad(g.tb) || idx_bad(g.tc) || trio_dup;
      default: return 1'b1;
    endcase
  endfunction

  // One gate step; rev selects the inverse where it differs (Peres).
  function automatic logic [NLINES-1:0] gate_eval(gate_t g, logic [NLINES-1:0] v, logic rev);
    logic [NLINES-1:0] r;
    logic              bmid;
    r    = v;
    bmid = 1'b0;
    case (g.kind)
      K_INV:  r[g.ta] = ~v[g.ta];
      K_CNOT: r[g.ta] = v[g.ta] ^ v[g.tb];
      K_TOF:  r[g.ta] = v[g.ta] ^ (&(v | ~g.mask));
      K_PER: begin
        if (!rev) begin
          r[g.ta] = v[g.ta] ^ (v[g.tc] & v[g.tb]);
          r[g.tb] = v[g.tb] ^ v[g.tc];
        end else begin
          bmid    = v[g.tb] ^ v[g.tc];
          r[g.tb] = bmid;
          r[g.ta] = v[g.ta] ^ (v[g.tc] & bmid);
        end
      end
      K_FRED: begin
        if (v[g.tc]) begin
          r[g.ta] = v[g.tb];
          r[g.tb] = v[g.ta];
        end
      end
      default: r = v;
    endcase
    return r;
  endfunction

  // Power-up program: per result bit k, five Toffoli entries.
  function automatic gate_t default_gate(int i);
    gate_t g;
    int    k, j, rl, al, bl;
    g  = '{kind: K_NOP, mask: '0, ta: '0, tb: '0, tc: '0};
    if (i < ALU_LEN) begin
      k  = i / 5;
      j  = i % 5;
      rl = 9 + k;
      al = 5 + k;
      bl = 1 + k;
      g.kind = K_TOF;
      g.ta   = IDX_W'(rl);
      case (j)
        0: g.mask = '0;
        1: g.mask = (NLINES'(1) << al) | (NLINES'(1) << bl);
        2: g.mask = NLINES'(1) | (NLINES'(1) << al);
        3: g.mask = NLINES'(1) | (NLINES'(1) << bl);
        default: begin
          g.mask = NLINES'(1) | (NLINES'(1) << rl);
          g.ta   = IDX_W'(al);
        end
      endcase
    end
    return g;
  endfunction

endpackage

// File: rtl/rgc_progmem.sv
module rgc_progmem
  import rgc_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  gate_t         wdata,
  input  logic [AW-1:0] raddr,
  output gate_t         rdata
);

  gate_t mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)                          mem[i] <= default_gate(i);
      else if (we && waddr == AW'(i))      mem[i] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/rgc_sequencer.sv
module rgc_sequencer #(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dir,
  output logic          load,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] pc
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] cnt;
  logic          rev_q;

  assign load = start && !busy;
  assign pc   = rev_q ? (LAST - cnt) : cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt   <= '0;
      rev_q <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy  <= 1'b1;
        cnt   <= '0;
        rev_q <= dir;
      end else if (busy) begin
        if (cnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/rgc_gate_unit.sv
module rgc_gate_unit
  import rgc_pkg::*;
(
  input  gate_t             gate,
  input  logic [NLINES-1:0] cur,
  input  logic              rev,
  output logic [NLINES-1:0] nxt,
  output logic              bad,
  output logic [2:0]        cost
);

  always_comb begin
    bad  = gate_bad(gate);
    nxt  = gate_eval(gate, cur, rev);
    cost = gate_cost(gate.kind);
  end

endmodule

// File: rtl/rgc_engine.sv
module rgc_engine
  import rgc_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int COST_W = 12,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              reverse,
  input  logic [12:0]       line_in,
  input  logic              prog_we,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [27:0]       prog_data,
  output logic [12:0]       line_out,
  output logic              busy,
  output logic              done,
  output logic [COST_W-1:0] cost,
  output logic              err
);

  logic              seq_load;
  logic [ADDR_W-1:0] pc;
  logic              rev_run;
  gate_t             cur_gate;
  logic [12:0]       lines_q, lines_nxt;
  logic              gate_is_bad;
  logic [2:0]        gate_c;
  logic              step_fire, step_skip;
  logic [COST_W-1:0] cost_q;
  logic              err_q;

  rgc_sequencer #(.DEPTH(DEPTH), .AW(ADDR_W)) u_seq (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .dir  (reverse),
    .load (seq_load),
    .busy (busy),
    .done (done),
    .pc   (pc)
  );

  rgc_progmem #(.DEPTH(DEPTH), .AW(ADDR_W)) u_mem (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (prog_we && !busy),
    .waddr(prog_addr),
    .wdata(gate_t'(prog_data)),
    .raddr(pc),
    .rdata(cur_gate)
  );

  // Direction is latched at load; the sequencer reports it through pc order.
  always_ff @(posedge clk) begin
    if (!rst_n)        rev_run <= 1'b0;
    else if (seq_load) rev_run <= reverse;
  end

  rgc_gate_unit u_gate (
    .gate(cur_gate),
    .cur (lines_q),
    .rev (rev_run),
    .nxt (lines_nxt),
    .bad (gate_is_bad),
    .cost(gate_c)
  );

  assign step_fire = busy && !gate_is_bad;
  assign step_skip = busy && gate_is_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lines_q <= '0;
      cost_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      if (seq_load) begin
        lines_q <= line_in;
        cost_q  <= '0;
      end else if (step_fire) begin
        lines_q <= lines_nxt;
        cost_q  <= cost_q + COST_W'(gate_c);
      end
      if (step_skip) err_q <= 1'b1;
    end
  end

  assign line_out = lines_q;
  assign cost     = cost_q;
  assign err      = err_q;

endmodule

// File: rtl/rgc_engine_chk.sv
module rgc_engine_chk #(
  parameter int COST_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [12:0]       line_in,
  input logic [12:0]       line_out,
  input logic              busy,
  input logic              done,
  input logic [COST_W-1:0] cost,
  input logic              err,
  input logic              seq_load,
  input logic              step_fire,
  input logic              step_skip
);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_ends_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_run_exits_by_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !seq_load) |=> (busy || done));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !seq_load) |=> $stable(line_out));

  assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_load |=> (busy && line_out == $past(line_in) && cost == '0));

  assert_cost_grows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |=> (cost >= $past(cost)));

  assert_skip_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    step_skip |=> ($stable(line_out) && $stable(cost) && err));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

endmodule

bind rgc_engine rgc_engine_chk #(.COST_W(COST_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .line_in  (line_in),
  .line_out (line_out),
  .busy     (busy),
  .done     (done),
  .cost     (cost),
  .err      (err),
  .seq_load (seq_load),
  .step_fire(step_fire),
  .step_skip(step_skip)
);

// File: tb/sim_rgc_engine.sv
module sim_rgc_engine;

  localparam int DEPTH  = 32;
  localparam int AW     = 5;
  localparam int COST_W = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              reverse = 1'b0;
  logic [12:0]       line_in = '0;
  logic              prog_we = 1'b0;
  logic [AW-1:0]     prog_addr = '0;
  logic [27:0]       prog_data = '0;
  logic [12:0]       line_out;
  logic              busy, done, err;
  logic [COST_W-1:0] cost;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int waited;

  always #2 clk = ~clk;

  rgc_engine #(.DEPTH(DEPTH), .COST_W(COST_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .reverse(reverse),
    .line_in(line_in), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .line_out(line_out), .busy(busy),
    .done(done), .cost(cost), .err(err)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog R7 got=%0d expected<=150000 cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [27:0] mk(int kind, logic [12:0] mask, int ta, int tb, int tc);
    return {kind[2:0], mask, ta[3:0], tb[3:0], tc[3:0]};
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic put(int addr, logic [27:0] d);
    @(negedge clk);
    prog_we = 1'b1; prog_addr = AW'(addr); prog_data = d;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic clear_prog();
    for (int i = 0; i < DEPTH; i++) put(i, 28'd0);
  endtask

  // poke=1: during the run, pulse start with other data and try a store write.
  task automatic run(logic dir, logic [12:0] vin, bit poke);
    @(negedge clk);
    start = 1'b1; reverse = dir; line_in = vin;
    @(negedge clk);
    start = 1'b0;
    waited = 1;
    while (!done) begin
      if (poke && waited == 10) begin
        start = 1'b1; reverse = ~dir; line_in = ~vin;
        prog_we = 1'b1; prog_addr = '0; prog_data = 28'd0;
      end else begin
        start = 1'b0; prog_we = 1'b0;
      end
      @(negedge clk);
      waited++;
    end
    start = 1'b0; prog_we = 1'b0;
  endtask

  initial begin
    logic [12:0] vin, exp, got;
    logic [3:0]  a, b, r, an;
    logic        s;

    do_reset();
    chk("R1 line_out", 32'(line_out), 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 cost", 32'(cost), 0);
    chk("R1 err", 32'(err), 0);

    // R7 timing and R8 ignore, on the default program
    run(1'b0, {4'hF, 4'b1100, 4'b1010, 1'b0}, 1'b1);
    chk("R7 done latency", 32'(waited), DEPTH + 1);
    chk("R8 start ignored result", 32'(line_out), 32'({4'b1000, 4'b1100, 4'b1010, 1'b0}));
    @(negedge clk);
    chk("R7 done single pulse", 32'(done), 0);
    chk("R7 idle busy", 32'(busy), 0);
    repeat (3) @(negedge clk);
    chk("R7 idle hold", 32'(line_out), 32'({4'b1000, 4'b1100, 4'b1010, 1'b0}));
    // store write during busy must not have cleared entry 0
    run(1'b0, {4'hF, 4'b1111, 4'b1111, 1'b0}, 1'b0);
    chk("R8 write ignored", 32'(line_out), 32'({4'hF, 4'hF, 4'hF, 1'b0}));

    // R10 / R5 / R6: exhaustive default-program sweep, forward then back
    for (int v = 0; v < 512; v++) begin
      s  = v[0];
      b  = v[4:1];
      a  = v[8:5];
      vin = {4'hF, a, b, s};
      r  = s ? (a | b) : (a & b);
      an = s ? (~a & b) : a;
      exp = {r, an, b, s};
      run(1'b0, vin, 1'b0);
      got = line_out;
      chk("R10 alu forward", 32'(got), 32'(exp));
      chk("R6 alu cost", 32'(cost), 100);
      run(1'b1, got, 1'b0);
      chk("R5 alu round trip", 32'(line_out), 32'(vin));
    end
    chk("R9 no err on default", 32'(err), 0);

    // R2 / R3 / R4 / R6 single gates
    clear_prog();
    run(1'b0, 13'h0A5A, 1'b0);
    chk("R2 empty program", 32'(line_out), 32'h0A5A);
    chk("R2 empty cost", 32'(cost), 0);

    put(0, mk(1, 13'h0, 3, 0, 0));
    run(1'b0, 13'h0A5A, 1'b0);
    chk("R4 invert", 32'(line_out), 32'h0A52);
    chk("R6 invert cost", 32'(cost), 0);

    put(0, mk(2, 13'h0, 2, 7, 0));
    run(1'b0, 13'h0080, 1'b0);
    chk("R4 cnot", 32'(line_out), 32'h0084);
    chk("R6 cnot cost", 32'(cost), 1);
    run(1'b0, 13'h0004, 1'b0);
    chk("R4 cnot ctrl low", 32'(line_out), 32'h0004);

    put(0, mk(3, 13'h0, 12, 0, 0));
    run(1'b0, 13'h0000, 1'b0);
    chk("R3 toffoli no controls", 32'(line_out), 32'h1000);
    chk("R6 toffoli cost", 32'(cost), 5);

    put(0, mk(3, 13'h1FFE, 0, 0, 0));
    run(1'b0, 13'h1FFE, 1'b0);
    chk("R3 toffoli 12 controls set", 32'(line_out), 32'h1FFF);
    run(1'b0, 13'h1FFC, 1'b0);
    chk("R3 toffoli one control low", 32'(line_out), 32'h1FFC);

    put(0, mk(4, 13'h0, 2, 6, 10));
    run(1'b0, 13'h0440, 1'b0);
    chk("R4 peres forward", 32'(line_out), 32'h0404);
    chk("R6 peres cost", 32'(cost), 4);
    run(1'b1, 13'h0404, 1'b0);
    chk("R5 peres inverse", 32'(line_out), 32'h0440);
    run(1'b1, 13'h0400, 1'b0);
    chk("R5 peres reverse differs", 32'(line_out), 32'h0444);

    put(0, mk(5, 13'h0, 1, 4, 11));
    run(1'b0, 13'h0802, 1'b0);
    chk("R4 fredkin swap", 32'(line_out), 32'h0810);
    chk("R6 fredkin cost", 32'(cost), 5);
    run(1'b0, 13'h0002, 1'b0);
    chk("R4 fredkin hold", 32'(line_out), 32'h0002);

    // R5 ordering: two dependent entries
    put(0, mk(2, 13'h0, 1, 0, 0));
    put(1, mk(3, 13'h0002, 2, 0, 0));
    run(1'b0, 13'h0001, 1'b0);
    chk("R5 forward order", 32'(line_out), 32'h0007);
    chk("R6 two-gate cost", 32'(cost), 6);
    run(1'b1, 13'h0001, 1'b0);
    chk("R5 reverse order", 32'(line_out), 32'h0003);
    run(1'b1, 13'h0007, 1'b0);
    chk("R5 round trip pair", 32'(line_out), 32'h0001);
    chk("R9 err still clear", 32'(err), 0);

    // R9 illegal entries
    put(1, 28'd0);
    put(0, mk(3, 13'h0010, 4, 0, 0));
    run(1'b0, 13'h1FFF, 1'b0);
    chk("R9 mask holds target", 32'(line_out), 32'h1FFF);
    chk("R9 skipped cost", 32'(cost), 0);
    chk("R9 err set", 32'(err), 1);
    put(0, mk(1, 13'h0, 3, 0, 0));
    run(1'b0, 13'h0000, 1'b0);
    chk("R9 err sticky", 32'(err), 1);
    chk("R9 legal after skip", 32'(line_out), 32'h0008);
    do_reset();
    chk("R1 err cleared", 32'(err), 0);
    clear_prog();
    put(0, mk(7, 13'h0, 0, 0, 0));
    put(1, mk(5, 13'h0, 1, 1, 11));
    put(2, mk(2, 13'h0, 13, 0, 0));
    run(1'b0, 13'h0803, 1'b0);
    chk("R9 bad kind and dup", 32'(line_out), 32'h0803);
    chk("R9 err bad kind", 32'(err), 1);
    chk("R9 cost bad", 32'(cost), 0);

    do_reset();
    run(1'b0, {4'hF, 4'b0101, 4'b0011, 1'b1}, 1'b0);
    chk("R1 default program restored", 32'(line_out), 32'({4'b0111, 4'b0010, 4'b0011, 1'b1}));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule